// File: doc/BRIEF.md
# Priority Interrupt Controller with Fast Vectors

This block arbitrates a parameterised set of interrupt request lines (66 by default) for a 16-bit signal-processing core. Over a small write/read register bus, software gives every programmable source a 2-bit priority code: the code either disables the source or places it at one of three levels. A small number of low-numbered sources are wired to the top level and cannot be reprogrammed. Requests are first encoded level by level, lowest vector number first. The highest populated level then supplies the winner. The winner is forwarded to the core only when its level is at least the core's current priority mask.

The block presents the winning vector number and a 21-bit handler address. Normally the address is the programmable vector base plus twice the vector number. Two match slots each hold a vector number and a direct 21-bit handler address. When the winner is at level 2 and equals a slot's number, the slot's address is sent out instead and a fast flag is raised. The request and its vector data are registered and stay unchanged until the core acknowledges. An acknowledge drops the request for exactly one cycle, and the next arbitration result is loaded on the following edge.

Top module: `prio_intc`

## Requirements
- R1: After reset, irq_o, vec_num_o, vec_addr_o and fast_o are 0. Every programmable priority field reads 00. The vector base reads 0. Both match slots read 7F (no source). Both slot addresses read 0.
- R2: Priority fields are 2 bits: 00 disabled, 01 level 0, 10 level 1, 11 level 2. Source 8k+j lives at bus address k, bits 2j+1:2j. A source coded 00 never produces irq_o.
- R3: The NUM_FIXED lowest sources (vectors 0 and 1 by default) always read 11 and ignore bus writes.
- R4: A pending request at a higher level wins over any request at a lower level, whatever the vector numbers.
- R5: Among pending requests at the winning level, the lowest vector number is chosen.
- R6: The core mask cur_mask_i gates the winner. irq_o is raised only when the winner's level is greater than or equal to the mask, so mask 3 blocks everything.
- R7: The normal vector address is (vector base + 2 × vector number) modulo 2^21. The base is written at bus address 9 (bits 15:0) and address 10 (bits 20:16).
- R8: Slot 0 uses addresses 11, 12 and 13, and slot 1 uses 14, 15 and 16. At each slot these are the match number, handler address bits 15:0 and handler address bits 20:16. When the winner is at level 2 and equals a slot's match number, vec_addr_o is that slot's address and fast_o is 1.
- R9: A winner that equals a match number but is not at level 2 gets the normal address, with fast_o 0.
- R10: While irq_o is high and irq_ack_i is low, irq_o, vec_num_o, vec_addr_o and fast_o hold their values, even if requests or the mask change.
- R11: irq_ack_i sampled while irq_o is high drops irq_o for exactly one cycle. If a qualifying request is then pending, irq_o rises again on the next edge with the new winner.
- R12: If both slots match the level-2 winner, slot 0's address is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 5 | Register address (writes and reads) |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for bus_addr_i |
| irq_req_i | input | 66 | Level-sensitive interrupt request lines |
| cur_mask_i | input | 2 | Core's current priority mask |
| irq_ack_i | input | 1 | Core acknowledge |
| irq_o | output | 1 | Interrupt request to the core |
| vec_num_o | output | 7 | Winning vector number |
| vec_addr_o | output | 21 | Handler address |
| fast_o | output | 1 | Winner is a fast interrupt |

## Verification
The assertions check on every cycle that held outputs do not change before an acknowledge, and that an acknowledge always drops the request. They also check that a newly raised request's level meets the mask of the previous cycle, that the fast flag appears only at level 2, and that the arbitrated winner really has its request line high. Only the bench's scenarios can show the actual ordering: level before vector number and lowest number within a level. The same holds for the address arithmetic, slot precedence, write protection of the fixed sources, and the exact one-cycle gap after an acknowledge. These are compared against a reference model driven by seeded random configurations and requests, and by directed cases.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int LEVELS = 3;
  localparam int SLOTS  = 2;
  typedef logic [1:0] prio_code_t;
  localparam prio_code_t PRIO_OFF = 2'b00;
  localparam prio_code_t PRIO_TOP = 2'b11;
endpackage

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int NUM_SRC   = 66,
  parameter int NUM_FIXED = 2,
  parameter int VEC_W     = 7,
  parameter int VA_W      = 21,
  parameter int BUS_AW    = 5,
  parameter int BUS_DW    = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [BUS_AW-1:0]            addr,
  input  logic [BUS_DW-1:0]            wdata,
  output logic [BUS_DW-1:0]            rdata,
  output logic [2*NUM_SRC-1:0]         prio_flat,
  output logic [VA_W-1:0]              vbase,
  output logic [SLOTS-1:0][VEC_W-1:0]  fmatch,
  output logic [SLOTS-1:0][VA_W-1:0]   faddr
);
  localparam int SPW        = BUS_DW / 2;
  localparam int PRIO_WORDS = (NUM_SRC + SPW - 1) / SPW;
  localparam int PAD_W      = PRIO_WORDS * BUS_DW;
  localparam int A_BASE_LO  = PRIO_WORDS;
  localparam int A_BASE_HI  = PRIO_WORDS + 1;
  localparam int A_SLOT0    = PRIO_WORDS + 2;
  localparam int HI_W       = VA_W - BUS_DW;

  // per-source priority fields
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    if (s < NUM_FIXED) begin : g_fixed
      assign prio_flat[2*s +: 2] = PRIO_TOP;
    end else begin : g_prog
      prio_code_t fld_q, fld_d;
      logic       fld_en;
      assign fld_en = wr_en && (addr == BUS_AW'(s / SPW));
      always_comb begin
        fld_d = fld_q;
        if (fld_en) fld_d = wdata[2*(s % SPW) +: 2];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fld_q <= PRIO_OFF;
        else        fld_q <= fld_d;
      end
      assign prio_flat[2*s +: 2] = fld_q;
    end
  end

  // vector base
  logic [VA_W-1:0] base_q, base_d;
  always_comb begin
    base_d = base_q;
    if (wr_en && addr == BUS_AW'(A_BASE_LO)) base_d[BUS_DW-1:0]    = wdata;
    if (wr_en && addr == BUS_AW'(A_BASE_HI)) base_d[VA_W-1:BUS_DW] = wdata[HI_W-1:0];
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else        base_q <= base_d;
  end
  assign vbase = base_q;

  // fast match slots
  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    logic [VEC_W-1:0] m_q, m_d;
    logic [VA_W-1:0]  a_q, a_d;
    always_comb begin
      m_d = m_q;
      a_d = a_q;
      if (wr_en && addr == BUS_AW'(A_SLOT0 + 3*k))     m_d = wdata[VEC_W-1:0];
      if (wr_en && addr == BUS_AW'(A_SLOT0 + 3*k + 1)) a_d[BUS_DW-1:0] = wdata;
      if (wr_en && addr == BUS_AW'(A_SLOT0 + 3*k + 2)) a_d[VA_W-1:BUS_DW] = wdata[HI_W-1:0];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        m_q <= '1;
        a_q <= '0;
      end else begin
        m_q <= m_d;
        a_q <= a_d;
      end
    end
    assign fmatch[k] = m_q;
    assign faddr[k]  = a_q;
  end

  // read mux
  logic [PAD_W-1:0] prio_pad;
  assign prio_pad = PAD_W'(prio_flat);
  always_comb begin
    rdata = '0;
    if (int'(addr) < PRIO_WORDS) rdata = prio_pad[int'(addr)*BUS_DW +: BUS_DW];
    if (addr == BUS_AW'(A_BASE_LO)) rdata = base_q[BUS_DW-1:0];
    if (addr == BUS_AW'(A_BASE_HI)) rdata = BUS_DW'(base_q[VA_W-1:BUS_DW]);
    for (int k = 0; k < SLOTS; k++) begin
      if (addr == BUS_AW'(A_SLOT0 + 3*k))     rdata = BUS_DW'(fmatch[k]);
      if (addr == BUS_AW'(A_SLOT0 + 3*k + 1)) rdata = faddr[k][BUS_DW-1:0];
      if (addr == BUS_AW'(A_SLOT0 + 3*k + 2)) rdata = BUS_DW'(faddr[k][VA_W-1:BUS_DW]);
    end
  end
endmodule

// File: rtl/intc_lvl_enc.sv
module intc_lvl_enc #(
  parameter int N  = 66,
  parameter int VW = 7
) (
  input  logic [N-1:0]  hits,
  output logic          found,
  output logic [VW-1:0] idx
);
  // lowest set index wins
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) idx = VW'(i);
    end
  end
  assign found = |hits;
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int NUM_SRC   = 66,
  parameter int NUM_FIXED = 2,
  parameter int VA_W      = 21,
  parameter int BUS_AW    = 5,
  parameter int BUS_DW    = 16,
  parameter int VEC_W     = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr_i,
  input  logic [BUS_AW-1:0]  bus_addr_i,
  input  logic [BUS_DW-1:0]  bus_wdata_i,
  output logic [BUS_DW-1:0]  bus_rdata_o,
  input  logic [NUM_SRC-1:0] irq_req_i,
  input  logic [1:0]         cur_mask_i,
  input  logic               irq_ack_i,
  output logic               irq_o,
  output logic [VEC_W-1:0]   vec_num_o,
  output logic [VA_W-1:0]    vec_addr_o,
  output logic               fast_o
);
  logic [2*NUM_SRC-1:0]        prio_flat;
  logic [VA_W-1:0]             vbase;
  logic [SLOTS-1:0][VEC_W-1:0] fmatch;
  logic [SLOTS-1:0][VA_W-1:0]  faddr;

  intc_regs #(
    .NUM_SRC(NUM_SRC), .NUM_FIXED(NUM_FIXED), .VEC_W(VEC_W),
    .VA_W(VA_W), .BUS_AW(BUS_AW), .BUS_DW(BUS_DW)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_i), .addr(bus_addr_i),
    .wdata(bus_wdata_i), .rdata(bus_rdata_o), .prio_flat(prio_flat),
    .vbase(vbase), .fmatch(fmatch), .faddr(faddr)
  );

  // per-level hit vectors and encoders
  logic [LEVELS-1:0][NUM_SRC-1:0] lvl_hits;
  logic [LEVELS-1:0]              lvl_found;
  logic [LEVELS-1:0][VEC_W-1:0]   lvl_idx;

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    always_comb begin
      for (int s = 0; s < NUM_SRC; s++)
        lvl_hits[l][s] = irq_req_i[s] && (prio_flat[2*s +: 2] == 2'(l + 1));
    end
    intc_lvl_enc #(.N(NUM_SRC), .VW(VEC_W)) u_enc (
      .hits(lvl_hits[l]), .found(lvl_found[l]), .idx(lvl_idx[l])
    );
  end

  // final winner: highest populated level
  logic             win_ok;
  logic [1:0]       win_lvl;
  logic [VEC_W-1:0] win_idx;
  always_comb begin
    win_ok  = 1'b0;
    win_lvl = '0;
    win_idx = '0;
    for (int l = 0; l < LEVELS; l++) begin
      if (lvl_found[l]) begin
        win_ok  = 1'b1;
        win_lvl = 2'(l);
        win_idx = lvl_idx[l];
      end
    end
  end

  logic pass;
  assign pass = win_ok && (win_lvl >= cur_mask_i);

  // fast slot match and address selection (slot 0 first)
  logic [SLOTS-1:0] slot_hit;
  for (genvar k = 0; k < SLOTS; k++) begin : g_hit
    assign slot_hit[k] = (win_lvl == 2'd2) && (win_idx == fmatch[k]);
  end

  logic [VA_W-1:0] addr_sel;
  logic            fast_sel;
  always_comb begin
    addr_sel = vbase + VA_W'({win_idx, 1'b0});
    fast_sel = 1'b0;
    for (int k = SLOTS - 1; k >= 0; k--) begin
      if (slot_hit[k]) begin
        addr_sel = faddr[k];
        fast_sel = 1'b1;
      end
    end
  end

  // output stage
  logic             irq_q, irq_d, load;
  logic [VEC_W-1:0] vec_q;
  logic [VA_W-1:0]  addr_q;
  logic             fast_q;
  logic [1:0]       lvl_q;

  always_comb begin
    irq_d = irq_q;
    load  = 1'b0;
    if (irq_q) begin
      if (irq_ack_i) irq_d = 1'b0;
    end else if (pass) begin
      irq_d = 1'b1;
      load  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      vec_q  <= '0;
      addr_q <= '0;
      fast_q <= 1'b0;
      lvl_q  <= '0;
    end else begin
      irq_q <= irq_d;
      if (load) begin
        vec_q  <= win_idx;
        addr_q <= addr_sel;
        fast_q <= fast_sel;
        lvl_q  <= win_lvl;
      end
    end
  end

  assign irq_o      = irq_q;
  assign vec_num_o  = vec_q;
  assign vec_addr_o = addr_q;
  assign fast_o     = fast_q;

  // R10: held outputs stable until acknowledged
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q && !irq_ack_i |=> irq_q && $stable(vec_q) && $stable(addr_q) && $stable(fast_q));

  // R11: acknowledge drops the request
  a_r11_ack_drop: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q && irq_ack_i |=> !irq_q);

  // R6: a newly raised request meets the mask it was qualified against
  a_r6_mask_met: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> lvl_q >= $past(cur_mask_i));

  // R8: fast flag only at level 2
  a_r8_fast_lvl: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q && fast_q |-> lvl_q == 2'd2);

  // R5: winner chosen by the encoders has its request line set
  a_r5_win_req: assert property (@(posedge clk) disable iff (!rst_n)
    win_ok |-> irq_req_i[win_idx]);
endmodule

// File: tb/prio_intc_test.sv
`timescale 1ns/1ps
module prio_intc_test;
  localparam int NS = 66;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [4:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic [NS-1:0] irq_req;
  logic [1:0]  mask;
  logic        ack;
  logic        irq;
  logic [6:0]  vnum;
  logic [20:0] vaddr;
  logic        fast;

  always #2.5 clk = ~clk;

  prio_intc uut (
    .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .irq_req_i(irq_req),
    .cur_mask_i(mask), .irq_ack_i(ack), .irq_o(irq), .vec_num_o(vnum),
    .vec_addr_o(vaddr), .fast_o(fast)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  int          m_prio [NS];
  int          d_prio [NS];
  logic [20:0] m_base;
  int          m_match [2];
  logic [20:0] m_fa [2];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic write_prio_all();
    for (int w = 0; w < 9; w++) begin
      logic [15:0] d = '0;
      for (int j = 0; j < 8; j++)
        if (w*8 + j < NS) d[2*j +: 2] = 2'(d_prio[w*8 + j]);
      bus_write(5'(w), d);
    end
    for (int s = 2; s < NS; s++) m_prio[s] = d_prio[s];
  endtask

  task automatic set_base(input logic [20:0] b);
    bus_write(5'd9, b[15:0]);
    bus_write(5'd10, {11'd0, b[20:16]});
    m_base = b;
  endtask

  task automatic set_slot(input int k, input int mt, input logic [20:0] a);
    bus_write(5'(11 + 3*k), 16'(mt));
    bus_write(5'(12 + 3*k), a[15:0]);
    bus_write(5'(13 + 3*k), {11'd0, a[20:16]});
    m_match[k] = mt;
    m_fa[k] = a;
  endtask

  task automatic model(input logic [NS-1:0] rq, input logic [1:0] mk,
                       output bit ok, output int vec, output logic [20:0] ad, output bit fs);
    int best = -1;
    vec = 0;
    for (int s = 0; s < NS; s++)
      if (rq[s] && m_prio[s] != 0 && (m_prio[s] - 1) > best) begin
        best = m_prio[s] - 1;
        vec = s;
      end
    ok = (best >= 0) && (best >= int'(mk));
    fs = 1'b0;
    ad = m_base + 21'(2*vec);
    if (best == 2) begin
      if (vec == m_match[0]) begin fs = 1'b1; ad = m_fa[0]; end
      else if (vec == m_match[1]) begin fs = 1'b1; ad = m_fa[1]; end
    end
  endtask

  task automatic clear_pending();
    @(negedge clk);
    irq_req = '0;
    if (irq) begin
      ack = 1'b1;
      @(posedge clk);
      @(negedge clk);
      ack = 1'b0;
    end
  endtask

  task automatic run_case(input logic [NS-1:0] rq, input logic [1:0] mk, input string tag);
    bit ok, fs; int vec; logic [20:0] ad;
    clear_pending();
    irq_req = rq; mask = mk;
    @(posedge clk);
    @(negedge clk);
    model(rq, mk, ok, vec, ad, fs);
    check(irq == ok, {tag, " irq"}, 32'(irq), 32'(ok));
    if (ok && irq) begin
      check(vnum == 7'(vec), {tag, " vector"}, 32'(vnum), 32'(vec));
      check(vaddr == ad, {tag, " address"}, 32'(vaddr), 32'(ad));
      check(fast == fs, {tag, " fast"}, 32'(fast), 32'(fs));
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    logic [NS-1:0] rq;
    void'($urandom(32'd4242));
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    irq_req = '0; mask = '0; ack = 1'b0;
    for (int s = 0; s < NS; s++) begin
      m_prio[s] = (s < 2) ? 3 : 0;
      d_prio[s] = 0;
    end
    m_base = '0; m_match[0] = 127; m_match[1] = 127; m_fa[0] = '0; m_fa[1] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    check(irq == 1'b0 && vnum == 0 && vaddr == 0 && fast == 1'b0, "R1 outputs",
          {vnum, irq, fast, 23'(vaddr)}, 32'd0);
    bus_read(5'd0, rd);  check(rd == 16'h000F, "R1 word0", rd, 16'h000F);
    bus_read(5'd5, rd);  check(rd == 16'h0000, "R1 word5", rd, 16'h0000);
    bus_read(5'd9, rd);  check(rd == 16'h0000, "R1 base", rd, 16'h0000);
    bus_read(5'd11, rd); check(rd == 16'h007F, "R1 slot0 match", rd, 16'h007F);
    bus_read(5'd14, rd); check(rd == 16'h007F, "R1 slot1 match", rd, 16'h007F);

    // R3 fixed sources ignore writes
    bus_write(5'd0, 16'h0000);
    bus_read(5'd0, rd); check(rd[3:0] == 4'hF, "R3 fixed fields", rd, 16'h000F);
    bus_write(5'd0, 16'h0024);
    bus_read(5'd0, rd); check(rd == 16'h002F, "R3 neighbour field", rd, 16'h002F);
    d_prio[2] = 2; m_prio[2] = 2;

    // R2 disabled source
    set_base(21'h01000);
    run_case(NS'(1) << 20, 2'd0, "R2 disabled");

    // R4 level ordering, R5 lowest vector, R7 address
    d_prio[10] = 1; d_prio[20] = 3; d_prio[30] = 2; d_prio[40] = 2; d_prio[50] = 2;
    write_prio_all();
    run_case((NS'(1) << 10) | (NS'(1) << 20), 2'd0, "R4 higher level");
    run_case((NS'(1) << 50) | (NS'(1) << 40) | (NS'(1) << 10), 2'd0, "R5 lowest vector");
    check(vnum == 7'd40 && vaddr == 21'h01050, "R7 normal address", vaddr, 21'h01050);

    // R6 mask gating
    run_case(NS'(1) << 40, 2'd2, "R6 mask above");
    run_case(NS'(1) << 40, 2'd1, "R6 mask equal");
    run_case(NS'(1) << 0, 2'd3, "R6 mask 3");

    // R8 fast, R9 non-level-2 match, R12 slot precedence
    set_slot(0, 20, 21'h12345);
    set_slot(1, 30, 21'h0ABCD);
    run_case(NS'(1) << 20, 2'd0, "R8 fast slot0");
    check(fast == 1'b1 && vaddr == 21'h12345, "R8 fast address", vaddr, 21'h12345);
    run_case(NS'(1) << 30, 2'd0, "R9 match level1");
    check(fast == 1'b0 && vaddr == 21'h0103C, "R9 normal address", vaddr, 21'h0103C);
    set_slot(1, 20, 21'h1F00F);
    run_case(NS'(1) << 20, 2'd0, "R12 both slots");
    check(vaddr == 21'h12345, "R12 slot0 wins", vaddr, 21'h12345);

    // R10 hold and R11 acknowledge gap
    run_case(NS'(1) << 40, 2'd0, "R10 setup");
    @(negedge clk);
    irq_req = (NS'(1) << 40) | (NS'(1) << 20);
    mask = 2'd2;
    for (int c = 0; c < 3; c++) begin
      @(posedge clk); @(negedge clk);
      check(irq && vnum == 7'd40 && fast == 1'b0, "R10 hold", vnum, 7'd40);
    end
    ack = 1'b1;
    @(posedge clk); @(negedge clk);
    ack = 1'b0;
    check(irq == 1'b0, "R11 gap cycle", irq, 1'b0);
    @(posedge clk); @(negedge clk);
    check(irq == 1'b1 && vnum == 7'd20, "R11 next winner", vnum, 7'd20);

    // constrained random
    for (int it = 0; it < 400; it++) begin
      if (it % 25 == 0) begin
        for (int s = 0; s < NS; s++) d_prio[s] = int'($urandom_range(0, 3));
        write_prio_all();
        set_base(21'($urandom));
        set_slot(0, int'($urandom_range(0, 69)), 21'($urandom));
        set_slot(1, int'($urandom_range(0, 69)), 21'($urandom));
      end
      rq = NS'({$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom});
      if ($urandom_range(0, 3) != 0) rq[1:0] = 2'b00;
      run_case(rq, 2'($urandom_range(0, 3)), "R4 R5 R6 R7 R8 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule